// File: doc/BRIEF.md
# Shared Cache Maintenance Command Queue

This block is the register front end through which several processors post maintenance commands to an outer cache. Each command invalidates, cleans or flushes either an address range or the whole cache. All processors share one register port. Every access on that port carries the id of the processor that makes it. The mode, address and size registers are common to all processors. A hardware lock decides which processor may write them. Each processor also has its own registration-status register and its own completion-status register.

The first processor to write the mode register becomes the owner of the shared registers. It keeps ownership until it reads its own registration-status register. That read is also the moment the command is registered. If no failure is reported, the command enters a small FIFO. A stub engine takes commands from the FIFO one at a time. Each command keeps the engine busy for a programmable number of cycles. When the command completes, the end flag is raised for the processor that issued it, provided that command asked for notification. A primitive register supports a sync request: a read of it is held off until the FIFO and the engine are both empty.

Top module: `maint_cmd_queue`

## Requirements
- R1: After reset the registration and completion status of every processor read 0, the engine is idle, the port is ready and the latency register (offset 6) reads 3.
- R2: The shared registers are mode (offset 0), address (offset 1) and size (offset 2). The first processor to write mode while no owner exists becomes owner. While it owns them, writes to them from any other processor are ignored. Such a write also sets that processor's registration-failure bit, which is bit 0 of the registration-status register at offset 3.
- R3: Ownership ends only when the owner reads its registration-status register. A read of that register by a non-owner leaves the lock in place. After release, another processor can take ownership and register a command.
- R4: A command is registered at the owner's releasing status read, and only if both failure bits would read 0. The engine then receives the command field (mode bits 1:0; 0 invalidate, 1 clean, 2 flush), the address, the size and the issuing processor id.
- R5: Mode bits 18:17 equal to 1 select whole-cache scope, and 0 selects range scope. A whole-cache command reaches the engine with address and size 0, whatever the address and size registers hold.
- R6: The FIFO holds DEPTH (4) waiting commands. A registration attempted while it is full reads back bit 1 (queue full) set, and the command is discarded.
- R7: Commands start on the engine one at a time and in the order they were registered.
- R8: A command keeps the engine busy for exactly L+1 cycles, where L is the value of the latency register.
- R9: Completion-status register (offset 4) bit 2 is the end flag. When a command completes, this flag is set only for the issuing processor, and only if that command had mode bit 15 (notify) set. Writing a 1 to bit 2 clears it. Writing a 0 there leaves it unchanged.
- R10: Completion-status bit 0 reads 1 while a command from that processor is waiting or running.
- R11: Writing 8 (sync) or 9 (prefetch-buffer flush) to the primitive register (offset 5) records that code. A read of that register is held off, with ready low, until the FIFO is empty and the engine is idle. It then returns the recorded code.
- R12: Completion-status bit 1 is set when a registration-status read reports any failure. Writing a 1 to bit 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Access accepted this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_cpu | input | CPU_W | Id of the requesting processor |
| req_reg | input | 3 | Register offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |
| exec_start | output | 1 | Pulse in the first busy cycle of a command |
| exec_busy | output | 1 | Engine executing a command |
| exec_cmd | output | 2 | Command field of the current command |
| exec_whole | output | 1 | Current command has whole-cache scope |
| exec_addr | output | ADDR_W | Address of the current command |
| exec_size | output | ADDR_W | Size of the current command |
| exec_cpu | output | CPU_W | Issuing processor of the current command |

## Verification
Range and whole-cache commands are posted from both processors. Their fields are compared with what the engine receives, which shows whether the scope masking and the command packing are right. Interleaved accesses let a second processor write the mode and address registers while the first one owns them. These show whether the lock protects the owner's values, and whether a non-owner read wrongly releases the lock. A long latency with six back-to-back posts fills the FIFO, which exposes errors in the full detection, in discard and in ordering. The sync read then has to wait for the whole backlog to drain. A short latency with a single command measures the exact busy length.

// File: rtl/mcq_pkg.sv
package mcq_pkg;
  typedef enum logic [2:0] {
    REG_MODE   = 3'd0,
    REG_ADDR   = 3'd1,
    REG_SIZE   = 3'd2,
    REG_REGST  = 3'd3,
    REG_DONEST = 3'd4,
    REG_PRIM   = 3'd5,
    REG_LAT    = 3'd6
  } reg_sel_e;

  localparam int MODE_NOTIFY_BIT = 15;
  localparam int MODE_SCOPE_LSB  = 17;
  localparam int REGST_FULL_BIT  = 1;
  localparam int REGST_FAIL_BIT  = 0;
  localparam int DONE_END_BIT    = 2;
  localparam int DONE_ERR_BIT    = 1;
  localparam int DONE_BUSY_BIT   = 0;
  localparam logic [1:0] SCOPE_WHOLE = 2'b01;
  localparam logic [3:0] PRIM_SYNC    = 4'h8;
  localparam logic [3:0] PRIM_PFFLUSH = 4'h9;
endpackage

// File: rtl/mcq_fifo.sv
module mcq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     head_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
  assign head_o  = mem[rp_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = do_push ? nxt(wp_q) : wp_q;
    rp_d  = do_pop  ? nxt(rp_q) : rp_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= data_i;
  end
endmodule

// File: rtl/mcq_exec.sv
module mcq_exec #(
  parameter int W     = 8,
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_empty_i,
  input  logic [W-1:0]     head_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             pop_o,
  output logic             busy_o,
  output logic             start_o,
  output logic             done_o,
  output logic [W-1:0]     cur_o
);
  logic             busy_q, busy_d, start_q, start_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     cur_q, cur_d;

  assign done_o  = busy_q && (cnt_q == '0);
  assign pop_o   = !q_empty_i && (!busy_q || done_o);
  assign busy_o  = busy_q;
  assign start_o = start_q;
  assign cur_o   = cur_q;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    cur_d   = cur_q;
    start_d = pop_o;
    if (pop_o) begin
      busy_d = 1'b1;
      cnt_d  = lat_i;
      cur_d  = head_i;
    end else if (done_o) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
      cur_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      cur_q   <= cur_d;
    end
  end
endmodule

// File: rtl/mcq_cpu_stat.sv
module mcq_cpu_stat #(
  parameter int CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fail_set_i,
  input  logic       stat_rd_i,
  input  logic       full_i,
  input  logic       clr_wr_i,
  input  logic [1:0] clr_data_i,
  input  logic       push_i,
  input  logic       done_i,
  input  logic       notify_i,
  output logic       fail_o,
  output logic       end_o,
  output logic       err_o,
  output logic       busy_o
);
  logic             fail_q, fail_d, end_q, end_d, err_q, err_d;
  logic [CNT_W-1:0] pend_q, pend_d;

  assign fail_o = fail_q;
  assign end_o  = end_q;
  assign err_o  = err_q;
  assign busy_o = (pend_q != '0);

  always_comb begin
    fail_d = fail_q;
    if (stat_rd_i) fail_d = 1'b0;
    else if (fail_set_i) fail_d = 1'b1;

    end_d = end_q;
    if (done_i && notify_i) end_d = 1'b1;
    else if (clr_wr_i && clr_data_i[1]) end_d = 1'b0;

    err_d = err_q;
    if (stat_rd_i && (fail_q || full_i)) err_d = 1'b1;
    else if (clr_wr_i && clr_data_i[0]) err_d = 1'b0;

    pend_d = pend_q;
    if (push_i && !done_i) pend_d = pend_q + 1'b1;
    else if (!push_i && done_i) pend_d = pend_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      end_q  <= 1'b0;
      err_q  <= 1'b0;
      pend_q <= '0;
    end else begin
      fail_q <= fail_d;
      end_q  <= end_d;
      err_q  <= err_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/maint_cmd_queue.sv
module maint_cmd_queue
  import mcq_pkg::*;
#(
  parameter int NCPU    = 2,
  parameter int DEPTH   = 4,
  parameter int ADDR_W  = 32,
  parameter int LAT_W   = 8,
  parameter int LAT_RST = 3,
  localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [2:0]        req_reg,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              exec_start,
  output logic              exec_busy,
  output logic [1:0]        exec_cmd,
  output logic              exec_whole,
  output logic [ADDR_W-1:0] exec_addr,
  output logic [ADDR_W-1:0] exec_size,
  output logic [CPU_W-1:0]  exec_cpu
);
  localparam int ENT_W   = CPU_W + 4 + 2 * ADDR_W;
  localparam int Q_CNT_W = $clog2(DEPTH + 1);
  localparam int P_CNT_W = $clog2(DEPTH + 2);
  localparam int NTF_POS = 2 * ADDR_W;
  localparam int WHL_POS = 2 * ADDR_W + 1;
  localparam int OP_LSB  = 2 * ADDR_W + 2;

  reg_sel_e sel;
  logic acc, wr_acc, rd_acc, drained;
  logic is_own, mode_ok, mode_wr, addr_wr, size_wr, regst_rd;
  logic my_fail, full_now, push, release_own;

  logic              own_vld_q, own_vld_d;
  logic [CPU_W-1:0]  own_id_q, own_id_d;
  logic [1:0]        mode_op_q, mode_op_d, mode_scope_q, mode_scope_d;
  logic              mode_ntf_q, mode_ntf_d;
  logic [ADDR_W-1:0] addr_q, addr_d, size_q, size_d;
  logic [3:0]        prim_q, prim_d;
  logic [LAT_W-1:0]  lat_q, lat_d;
  logic              rsp_valid_q;
  logic [31:0]       rsp_rdata_q, rd_mux;
  logic              whole_q;

  logic [ENT_W-1:0]   push_ent, head_ent, cur_ent;
  logic               q_full, q_empty, q_pop, exec_done;
  logic [Q_CNT_W-1:0] q_cnt;

  logic [NCPU-1:0] fail_vec, end_vec, err_vec, busy_vec;

  assign sel     = reg_sel_e'(req_reg);
  assign drained = q_empty && !exec_busy;
  assign req_ready = !(!req_write && (sel == REG_PRIM) && !drained);
  assign acc     = req_valid && req_ready;
  assign wr_acc  = acc && req_write;
  assign rd_acc  = acc && !req_write;

  assign is_own   = own_vld_q && (own_id_q == req_cpu);
  assign mode_ok  = !own_vld_q || is_own;
  assign mode_wr  = wr_acc && (sel == REG_MODE);
  assign addr_wr  = wr_acc && (sel == REG_ADDR);
  assign size_wr  = wr_acc && (sel == REG_SIZE);
  assign regst_rd = rd_acc && (sel == REG_REGST);
  assign my_fail  = fail_vec[req_cpu];
  assign full_now = is_own && q_full;
  assign push     = regst_rd && is_own && !my_fail && !q_full;
  assign release_own = regst_rd && is_own;
  assign whole_q  = (mode_scope_q == SCOPE_WHOLE);

  assign push_ent = {req_cpu, mode_op_q, whole_q, mode_ntf_q,
                     whole_q ? '0 : addr_q, whole_q ? '0 : size_q};

  // shared command registers and lock: next state
  always_comb begin
    own_vld_d    = own_vld_q;
    own_id_d     = own_id_q;
    mode_op_d    = mode_op_q;
    mode_scope_d = mode_scope_q;
    mode_ntf_d   = mode_ntf_q;
    addr_d       = addr_q;
    size_d       = size_q;
    prim_d       = prim_q;
    lat_d        = lat_q;
    if (mode_wr && mode_ok) begin
      own_vld_d    = 1'b1;
      own_id_d     = req_cpu;
      mode_op_d    = req_wdata[1:0];
      mode_ntf_d   = req_wdata[MODE_NOTIFY_BIT];
      mode_scope_d = req_wdata[MODE_SCOPE_LSB +: 2];
    end
    if (addr_wr && is_own) addr_d = req_wdata[ADDR_W-1:0];
    if (size_wr && is_own) size_d = req_wdata[ADDR_W-1:0];
    if (release_own) own_vld_d = 1'b0;
    if (wr_acc && (sel == REG_PRIM) &&
        ((req_wdata == 32'(PRIM_SYNC)) || (req_wdata == 32'(PRIM_PFFLUSH))))
      prim_d = req_wdata[3:0];
    if (wr_acc && (sel == REG_LAT)) lat_d = req_wdata[LAT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld_q    <= 1'b0;
      own_id_q     <= '0;
      mode_op_q    <= '0;
      mode_scope_q <= '0;
      mode_ntf_q   <= 1'b0;
      addr_q       <= '0;
      size_q       <= '0;
      prim_q       <= '0;
      lat_q        <= LAT_W'(LAT_RST);
    end else begin
      own_vld_q    <= own_vld_d;
      own_id_q     <= own_id_d;
      mode_op_q    <= mode_op_d;
      mode_scope_q <= mode_scope_d;
      mode_ntf_q   <= mode_ntf_d;
      addr_q       <= addr_d;
      size_q       <= size_d;
      prim_q       <= prim_d;
      lat_q        <= lat_d;
    end
  end

  // read data selection
  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_MODE: begin
        rd_mux[1:0]                   = mode_op_q;
        rd_mux[MODE_NOTIFY_BIT]       = mode_ntf_q;
        rd_mux[MODE_SCOPE_LSB +: 2]   = mode_scope_q;
      end
      REG_ADDR:  rd_mux[ADDR_W-1:0] = addr_q;
      REG_SIZE:  rd_mux[ADDR_W-1:0] = size_q;
      REG_REGST: begin
        rd_mux[REGST_FULL_BIT] = full_now;
        rd_mux[REGST_FAIL_BIT] = my_fail;
      end
      REG_DONEST: begin
        rd_mux[DONE_END_BIT]  = end_vec[req_cpu];
        rd_mux[DONE_ERR_BIT]  = err_vec[req_cpu];
        rd_mux[DONE_BUSY_BIT] = busy_vec[req_cpu];
      end
      REG_PRIM: rd_mux[3:0]       = prim_q;
      REG_LAT:  rd_mux[LAT_W-1:0] = lat_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_acc;
      if (rd_acc) rsp_rdata_q <= rd_mux;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;

  mcq_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (push),
    .data_i  (push_ent),
    .pop_i   (q_pop),
    .head_o  (head_ent),
    .full_o  (q_full),
    .empty_o (q_empty),
    .cnt_o   (q_cnt)
  );

  mcq_exec #(.W(ENT_W), .LAT_W(LAT_W)) u_exec (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_empty_i (q_empty),
    .head_i    (head_ent),
    .lat_i     (lat_q),
    .pop_o     (q_pop),
    .busy_o    (exec_busy),
    .start_o   (exec_start),
    .done_o    (exec_done),
    .cur_o     (cur_ent)
  );

  assign exec_cpu   = cur_ent[ENT_W-1 -: CPU_W];
  assign exec_cmd   = cur_ent[OP_LSB +: 2];
  assign exec_whole = cur_ent[WHL_POS];
  assign exec_addr  = cur_ent[ADDR_W +: ADDR_W];
  assign exec_size  = cur_ent[0 +: ADDR_W];

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    logic hit;
    assign hit = (req_cpu == CPU_W'(i));
    mcq_cpu_stat #(.CNT_W(P_CNT_W)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .fail_set_i (hit && ((mode_wr && !mode_ok) ||
                           ((addr_wr || size_wr) && !is_own))),
      .stat_rd_i  (hit && regst_rd),
      .full_i     (full_now),
      .clr_wr_i   (hit && wr_acc && (sel == REG_DONEST)),
      .clr_data_i (req_wdata[DONE_END_BIT:DONE_ERR_BIT]),
      .push_i     (hit && push),
      .done_i     (exec_done && (exec_cpu == CPU_W'(i))),
      .notify_i   (cur_ent[NTF_POS]),
      .fail_o     (fail_vec[i]),
      .end_o      (end_vec[i]),
      .err_o      (err_vec[i]),
      .busy_o     (busy_vec[i])
    );
  end
endmodule

// File: rtl/maint_cmd_queue_chk.sv
module maint_cmd_queue_chk #(
  parameter int DEPTH   = 4,
  parameter int CPU_W   = 1,
  parameter int ADDR_W  = 32,
  parameter int Q_CNT_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic               rsp_valid,
  input logic               exec_start,
  input logic               exec_busy,
  input logic               exec_whole,
  input logic [ADDR_W-1:0]  exec_addr,
  input logic [ADDR_W-1:0]  exec_size,
  input logic [Q_CNT_W-1:0] q_cnt,
  input logic               q_empty,
  input logic               own_vld_q,
  input logic [CPU_W-1:0]   own_id_q
);
  // R6
  q_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= Q_CNT_W'(DEPTH));

  // R2
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_vld_q && $past(own_vld_q)) |-> (own_id_q == $past(own_id_q)));

  // R7
  start_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_busy) |-> exec_start);

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> exec_busy);

  // R5
  whole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_start && exec_whole) |-> (exec_addr == '0 && exec_size == '0));

  // R11
  stall_reason_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !(q_empty && !exec_busy));

  // R4
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
endmodule

bind maint_cmd_queue maint_cmd_queue_chk #(
  .DEPTH(DEPTH), .CPU_W(CPU_W), .ADDR_W(ADDR_W), .Q_CNT_W(Q_CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .exec_start (exec_start),
  .exec_busy  (exec_busy),
  .exec_whole (exec_whole),
  .exec_addr  (exec_addr),
  .exec_size  (exec_size),
  .q_cnt      (q_cnt),
  .q_empty    (q_empty),
  .own_vld_q  (own_vld_q),
  .own_id_q   (own_id_q)
);

// File: tb/maint_cmd_queue_test.sv
`timescale 1ns/1ps
module maint_cmd_queue_test;
  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [0:0]  req_cpu;
  logic [2:0]  req_reg;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        exec_start, exec_busy, exec_whole;
  logic [1:0]  exec_cmd;
  logic [31:0] exec_addr, exec_size;
  logic [0:0]  exec_cpu;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic [31:0] log_addr [32];
  logic [31:0] log_size [32];
  logic [1:0]  log_op   [32];
  logic        log_whl  [32];
  logic        log_cpu  [32];
  int          log_n = 0;

  maint_cmd_queue uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cpu(req_cpu), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .exec_start(exec_start), .exec_busy(exec_busy), .exec_cmd(exec_cmd),
    .exec_whole(exec_whole), .exec_addr(exec_addr), .exec_size(exec_size),
    .exec_cpu(exec_cpu)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && exec_start && log_n < 32) begin
      log_addr[log_n] = exec_addr;
      log_size[log_n] = exec_size;
      log_op[log_n]   = exec_cmd;
      log_whl[log_n]  = exec_whole;
      log_cpu[log_n]  = exec_cpu[0];
      log_n = log_n + 1;
    end
  end

  localparam int O_MODE = 0, O_ADDR = 1, O_SIZE = 2, O_REGST = 3,
                 O_DONE = 4, O_PRIM = 5, O_LAT = 6;

  function automatic logic [31:0] mk_mode(input int ntf, input int scope, input int op);
    return (32'(ntf) << 15) | (32'(scope) << 17) | 32'(op);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input int cpu, input logic wr, input int off,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cpu = 1'(cpu);
    req_reg = 3'(off); req_wdata = wd;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
  endtask

  task automatic wr(input int cpu, input int off, input logic [31:0] d);
    logic [31:0] dummy;
    access(cpu, 1'b1, off, d, dummy);
  endtask

  task automatic rd(input int cpu, input int off, output logic [31:0] d);
    access(cpu, 1'b0, off, 32'h0, d);
  endtask

  task automatic post(input int cpu, input logic [31:0] mode, input logic [31:0] a,
                      input logic [31:0] s, output logic [31:0] st);
    wr(cpu, O_MODE, mode);
    wr(cpu, O_ADDR, a);
    wr(cpu, O_SIZE, s);
    rd(cpu, O_REGST, st);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, O_REGST, v); chk("R1 regstat cpu0", v, 0);
    rd(0, O_DONE, v);  chk("R1 done cpu0", v, 0);
    rd(1, O_DONE, v);  chk("R1 done cpu1", v, 0);
    rd(0, O_LAT, v);   chk("R1 latency", v, 3);
    chk("R1 engine idle", 32'(exec_busy), 0);
    chk("R1 ready", 32'(req_ready), 1);
  endtask

  task automatic t_range();
    logic [31:0] v;
    int b = log_n;
    post(0, mk_mode(1, 0, 2), 32'h1000, 32'h40, v);
    chk("R4 regstat ok", v, 0);
    rd(0, O_PRIM, v); chk("R11 prim reset value", v, 0);
    chk("R4 one start", 32'(log_n - b), 1);
    chk("R4 op", 32'(log_op[b]), 2);
    chk("R4 range", 32'(log_whl[b]), 0);
    chk("R4 addr", log_addr[b], 32'h1000);
    chk("R4 size", log_size[b], 32'h40);
    chk("R4 cpu", 32'(log_cpu[b]), 0);
    rd(0, O_DONE, v); chk("R9 end set cpu0", v, 4);
    rd(1, O_DONE, v); chk("R9 other cpu untouched", v, 0);
    wr(0, O_DONE, 0);
    rd(0, O_DONE, v); chk("R9 write 0 keeps end", v, 4);
    wr(0, O_DONE, 4);
    rd(0, O_DONE, v); chk("R9 write 1 clears end", v, 0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    int b = log_n;
    wr(0, O_MODE, mk_mode(0, 0, 1));
    wr(1, O_MODE, mk_mode(0, 1, 0));
    wr(1, O_ADDR, 32'hBAD0);
    wr(0, O_ADDR, 32'h2000);
    wr(0, O_SIZE, 32'h80);
    rd(1, O_REGST, v); chk("R2 non-owner fail bit", v, 1);
    rd(1, O_DONE, v);  chk("R12 err bit on fail", v, 2);
    rd(0, O_REGST, v); chk("R3 owner still holds lock", v, 0);
    rd(0, O_PRIM, v);
    chk("R2 owner command started", 32'(log_n - b), 1);
    chk("R2 owner op kept", 32'(log_op[b]), 1);
    chk("R2 owner scope kept", 32'(log_whl[b]), 0);
    chk("R2 owner addr kept", log_addr[b], 32'h2000);
    chk("R2 owner size", log_size[b], 32'h80);
    post(1, mk_mode(0, 0, 0), 32'h3000, 32'h20, v);
    chk("R3 second cpu registers", v, 0);
    rd(1, O_PRIM, v);
    chk("R3 second start", 32'(log_n - b), 2);
    chk("R3 second cpu id", 32'(log_cpu[b+1]), 1);
    chk("R3 second addr", log_addr[b+1], 32'h3000);
    wr(1, O_DONE, 2);
    rd(1, O_DONE, v); chk("R12 err cleared", v, 0);
  endtask

  task automatic t_whole();
    logic [31:0] v;
    int b = log_n;
    post(1, mk_mode(0, 1, 1), 32'hDEAD, 32'hBEEF, v);
    chk("R5 regstat ok", v, 0);
    rd(1, O_PRIM, v);
    chk("R5 whole flag", 32'(log_whl[b]), 1);
    chk("R5 addr masked", log_addr[b], 0);
    chk("R5 size masked", log_size[b], 0);
    chk("R5 op clean", 32'(log_op[b]), 1);
    rd(1, O_DONE, v); chk("R9 no notify no end", v, 0);
  endtask

  task automatic t_full();
    logic [31:0] v;
    int b = log_n;
    wr(0, O_LAT, 200);
    for (int k = 0; k < 5; k++) begin
      post(0, mk_mode(0, 0, 2), 32'(32'h100 * (k + 1)), 32'h40, v);
      chk("R6 accepted while room", v, 0);
    end
    post(0, mk_mode(0, 0, 2), 32'h600, 32'h40, v);
    chk("R6 full reported", v, 2);
    rd(0, O_DONE, v); chk("R10 busy while pending", v, 3);
    rd(1, O_DONE, v); chk("R10 other cpu not busy", v, 0);
    wr(0, O_PRIM, 8);
    rd(0, O_PRIM, v); chk("R11 sync code after drain", v, 8);
    chk("R11 engine idle after sync read", 32'(exec_busy), 0);
    chk("R6 discarded command absent", 32'(log_n - b), 5);
    for (int k = 0; k < 5; k++)
      chk("R7 order", log_addr[b+k], 32'(32'h100 * (k + 1)));
    rd(0, O_DONE, v); chk("R10 busy cleared", v, 2);
    wr(0, O_DONE, 2);
  endtask

  task automatic t_lat();
    logic [31:0] v;
    int n = 0;
    wr(0, O_LAT, 5);
    wr(0, O_PRIM, 9);
    post(0, mk_mode(0, 0, 0), 32'h40, 32'h40, v);
    while (!exec_start) @(negedge clk);
    while (exec_busy) begin n++; @(negedge clk); end
    chk("R8 busy length", 32'(n), 6);
    rd(0, O_PRIM, v); chk("R11 prefetch code", v, 9);
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_cpu = 0; req_reg = 0; req_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_range();
    t_lock();
    t_whole();
    t_full();
    t_lat();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule